// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides which reset is in force and steps the chip through the matching sequence. Four kinds of reset reach it. The power-on pin `rst_ni` comes first and outranks every other source. The warm reset pin comes next, followed by software requests and watchdog timeouts. Software and watchdog requests each come in a soft kind and a system kind. After power-on the block latches the PLL multiplier and raises the PLL start request. It then counts a lock delay, captures a configuration word from the shared address/data bus, and runs an internal reset period. At the end of that period it frees the system logic first and then CPU0 one cycle later.

During the internal period the block drives the board, PCI and serial-link reset outputs. The link power-good output drops only when the sequence began with a cold reset. Outside the internal period, software can hold the board and link resets through a small control register. A cause register keeps a one-hot record of the last reset. Each source runs only its own part of the sequence. A warm reset skips the PLL start, the lock delay and the configuration capture. A software system reset captures the configuration word again but keeps the PLL ratio. A watchdog system reset keeps both.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, every reset output (`sys_rst_no`, `cpu0_rst_no`, `board_rst_no`, `pci_rst_no`, `link_rst_no`) is low, `link_pwrok_o` is low, `pll_start_o` is low and `cause_o` reads 6'b000001.
- R2: `rst_ni` passes through a two-stage synchronizer. On the third rising clock edge after `rst_ni` rises, `pll_start_o` goes high and `pll_mult_o` takes the value `pll_mult_i` had at that edge. The PLL start stays high and the multiplier stays unchanged until the next cold reset.
- R3: The lock delay lasts LOCK_CYC cycles, counted from the edge that raises `pll_start_o`. `cfg_o` takes the value of `cfg_bus_i` at the edge that ends the delay.
- R4: The internal reset period lasts INT_CYC cycles. `sys_rst_no` rises at the edge that ends it and `cpu0_rst_no` rises one cycle later. After a cold release this is edge 3+LOCK_CYC+INT_CYC for `sys_rst_no`.
- R5: A warm reset (`warm_rst_ni` low) outside the cold sequence enters reset on the next edge. It keeps `pll_start_o` high, leaves `cfg_o` and `pll_mult_o` unchanged and has no lock delay. The internal period starts on the third edge after the pin rises.
- R6: `warm_rst_ni` is ignored during the cold sequence up to the end of the lock delay. A warm pulse there does not change any release timing.
- R7: During the internal period, `pci_rst_no` and `link_rst_no` are low. `link_pwrok_o` is low only if the sequence began with a cold reset.
- R8: When `ctrl_we_i` is high outside the internal period, `ctrl_board_i` and `ctrl_link_i` are stored and drive `board_rst_no` and `link_rst_no` low when set. `pci_rst_no` has no software control. Writes made during reset are dropped. Any internal period clears the stored bits.
- R9: Soft resets leave `board_rst_no` high. System resets and warm resets drive it low for the internal period.
- R10: A software system reset captures `cfg_bus_i` at its accepting edge into `cfg_o`. A watchdog system reset or a soft reset changes neither `cfg_o` nor `pll_mult_o`.
- R11: Requests are taken only while running (CPU0 released), in this priority order: warm, then watchdog system, then software system, then watchdog soft, then software soft. Requests made during a sequence are ignored.
- R12: `cause_o` is one-hot with bit 0 cold, bit 1 warm, bit 2 software soft, bit 3 software system, bit 4 watchdog soft and bit 5 watchdog system. It is set by the reset that wins and is cleared back to the cold value only by `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on cold reset, active low, asynchronous |
| warm_rst_ni | input | 1 | Warm reset pin, active low, asynchronous |
| sw_soft_req_i | input | 1 | Software soft reset request |
| sw_sys_req_i | input | 1 | Software system reset request |
| wdt_soft_req_i | input | 1 | Watchdog soft reset request |
| wdt_sys_req_i | input | 1 | Watchdog system reset request |
| pll_mult_i | input | MULT_W | PLL multiplier straps |
| cfg_bus_i | input | CFG_W | Shared address/data lines carrying the configuration word |
| ctrl_we_i | input | 1 | Write strobe for the output control bits |
| ctrl_board_i | input | 1 | Software board reset bit |
| ctrl_link_i | input | 1 | Software link reset bit |
| pll_start_o | output | 1 | PLL start request |
| pll_mult_o | output | MULT_W | Latched PLL multiplier |
| cfg_o | output | CFG_W | Captured configuration word |
| sys_rst_no | output | 1 | System logic reset, active low |
| cpu0_rst_no | output | 1 | CPU0 reset, active low |
| board_rst_no | output | 1 | Board reset output, active low |
| pci_rst_no | output | 1 | PCI reset output, active low |
| link_rst_no | output | 1 | Serial-link reset output, active low |
| link_pwrok_o | output | 1 | Serial-link power-good |
| cause_o | output | 6 | One-hot cause of the last reset |

## Verification
The bench builds the block with LOCK_CYC=8, INT_CYC=4, an 8-bit configuration word and a 4-bit multiplier. With these values every sequence fits in a few dozen cycles, so the bench can follow each edge of each sequence and predict exactly where every output changes. It drives the bus and strap inputs with a value that changes every cycle, which shows the exact capture edge. It also runs through all 16 combinations of the four software and watchdog requests, plus all four control-bit patterns, checking priority, board assertion and configuration capture for each.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    S_COLD, S_LOCK, S_WARM, S_INTR, S_RELS, S_RUN
  } seq_state_e;

  localparam int CAUSE_W    = 6;
  localparam int C_COLD     = 0;
  localparam int C_WARM     = 1;
  localparam int C_SW_SOFT  = 2;
  localparam int C_SW_SYS   = 3;
  localparam int C_WDT_SOFT = 4;
  localparam int C_WDT_SYS  = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_COLD = CAUSE_W'(1) << C_COLD;
  localparam logic [CAUSE_W-1:0] CAUSE_WARM = CAUSE_W'(1) << C_WARM;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic sync_no
);
  logic [STAGES-1:0] q;

  // async assert, synchronous release
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else          q <= {q[STAGES-2:0], 1'b1};
  end

  assign sync_no = q[STAGES-1];
endmodule

// File: rtl/rst_req_arb.sv
module rst_req_arb
  import rst_seq_pkg::*;
(
  input  logic               sw_soft_i,
  input  logic               sw_sys_i,
  input  logic               wdt_soft_i,
  input  logic               wdt_sys_i,
  output logic [CAUSE_W-1:0] grant_o
);
  always_comb begin
    grant_o = '0;
    if      (wdt_sys_i)  grant_o[C_WDT_SYS]  = 1'b1;
    else if (sw_sys_i)   grant_o[C_SW_SYS]   = 1'b1;
    else if (wdt_soft_i) grant_o[C_WDT_SOFT] = 1'b1;
    else if (sw_soft_i)  grant_o[C_SW_SOFT]  = 1'b1;
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int LOCK_CYC = 1024,
  parameter int INT_CYC  = 64
) (
  input  logic               clk_i,
  input  logic               rst_sync_ni,
  input  logic               warm_sync_ni,
  input  logic [CAUSE_W-1:0] grant_i,
  output seq_state_e         state_o,
  output logic               board_seq_o,
  output logic               link_cold_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               mult_cap_o,
  output logic               cfg_cap_o
);
  localparam int MAXC  = (LOCK_CYC > INT_CYC) ? LOCK_CYC : INT_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] INT_LAST  = CNT_W'(INT_CYC - 1);

  seq_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               board_q, board_d, linkc_q, linkc_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               warm_hit;

  // warm pin only counts once the cold flow has finished its lock delay
  assign warm_hit = !warm_sync_ni &&
                    (state_q inside {S_INTR, S_RELS, S_RUN});

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    board_d    = board_q;
    linkc_d    = linkc_q;
    cause_d    = cause_q;
    mult_cap_o = 1'b0;
    cfg_cap_o  = 1'b0;
    if (warm_hit) begin
      state_d = S_WARM;
      board_d = 1'b1;
      linkc_d = 1'b0;
      cause_d = CAUSE_WARM;
    end else begin
      unique case (state_q)
        S_COLD: begin
          state_d    = S_LOCK;
          cnt_d      = '0;
          mult_cap_o = 1'b1;
        end
        S_LOCK: begin
          if (cnt_q == LOCK_LAST) begin
            state_d   = S_INTR;
            cnt_d     = '0;
            cfg_cap_o = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_WARM: begin
          if (warm_sync_ni) begin
            state_d = S_INTR;
            cnt_d   = '0;
          end
        end
        S_INTR: begin
          if (cnt_q == INT_LAST) state_d = S_RELS;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        S_RELS: state_d = S_RUN;
        S_RUN: begin
          if (|grant_i) begin
            state_d   = S_INTR;
            cnt_d     = '0;
            board_d   = grant_i[C_SW_SYS] | grant_i[C_WDT_SYS];
            linkc_d   = 1'b0;
            cause_d   = grant_i;
            cfg_cap_o = grant_i[C_SW_SYS];
          end
        end
        default: state_d = S_COLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_ni) begin
    if (!rst_sync_ni) begin
      state_q <= S_COLD;
      cnt_q   <= '0;
      board_q <= 1'b1;
      linkc_q <= 1'b1;
      cause_q <= CAUSE_COLD;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      board_q <= board_d;
      linkc_q <= linkc_d;
      cause_q <= cause_d;
    end
  end

  assign state_o     = state_q;
  assign board_seq_o = board_q;
  assign link_cold_o = linkc_q;
  assign cause_o     = cause_q;

  a_r4_cpu_after_sys: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (state_q == S_RUN) |-> ($past(state_q) == S_RELS || $past(state_q) == S_RUN));
  a_r5_warm_no_lock: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (state_q == S_WARM) |=> (state_q inside {S_WARM, S_INTR}));
  a_r6_lock_uninterrupted: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (state_q == S_LOCK && cnt_q != LOCK_LAST) |=> (state_q == S_LOCK));
  a_r11_no_req_in_seq: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (state_q == S_INTR && warm_sync_ni) |=> (state_q inside {S_INTR, S_RELS}));
  a_r12_cause_onehot: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    $countones(cause_q) == 1);
endmodule

// File: rtl/rst_cfg_capture.sv
module rst_cfg_capture #(
  parameter int MULT_W = 6,
  parameter int CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_sync_ni,
  input  logic              mult_cap_i,
  input  logic              cfg_cap_i,
  input  logic [MULT_W-1:0] pll_mult_i,
  input  logic [CFG_W-1:0]  cfg_bus_i,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [CFG_W-1:0]  cfg_o
);
  always_ff @(posedge clk_i or negedge rst_sync_ni) begin
    if (!rst_sync_ni) begin
      pll_mult_o <= '0;
      cfg_o      <= '0;
    end else begin
      if (mult_cap_i) pll_mult_o <= pll_mult_i;
      if (cfg_cap_i)  cfg_o      <= cfg_bus_i;
    end
  end
endmodule

// File: rtl/rst_out_ctrl.sv
module rst_out_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_sync_ni,
  input  seq_state_e state_i,
  input  logic       board_seq_i,
  input  logic       link_cold_i,
  input  logic       ctrl_we_i,
  input  logic       ctrl_board_i,
  input  logic       ctrl_link_i,
  output logic       pll_start_o,
  output logic       sys_rst_no,
  output logic       cpu0_rst_no,
  output logic       board_rst_no,
  output logic       pci_rst_no,
  output logic       link_rst_no,
  output logic       link_pwrok_o
);
  logic in_int, sw_board_q, sw_link_q;

  assign in_int = state_i inside {S_COLD, S_LOCK, S_WARM, S_INTR};

  always_ff @(posedge clk_i or negedge rst_sync_ni) begin
    if (!rst_sync_ni) begin
      sw_board_q <= 1'b0;
      sw_link_q  <= 1'b0;
    end else if (in_int) begin
      sw_board_q <= 1'b0;
      sw_link_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      sw_board_q <= ctrl_board_i;
      sw_link_q  <= ctrl_link_i;
    end
  end

  assign pll_start_o  = (state_i != S_COLD);
  assign sys_rst_no   = !in_int;
  assign cpu0_rst_no  = (state_i == S_RUN);
  assign board_rst_no = !((in_int && board_seq_i) || sw_board_q);
  assign pci_rst_no   = !in_int;
  assign link_rst_no  = !(in_int || sw_link_q);
  assign link_pwrok_o = !(in_int && link_cold_i);

  a_r8_sw_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (state_i == S_INTR) |=> (!sw_board_q && !sw_link_q));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int LOCK_CYC = 1024,
  parameter int INT_CYC  = 64,
  parameter int MULT_W   = 6,
  parameter int CFG_W    = 16,
  parameter int SYNC_N   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               warm_rst_ni,
  input  logic               sw_soft_req_i,
  input  logic               sw_sys_req_i,
  input  logic               wdt_soft_req_i,
  input  logic               wdt_sys_req_i,
  input  logic [MULT_W-1:0]  pll_mult_i,
  input  logic [CFG_W-1:0]   cfg_bus_i,
  input  logic               ctrl_we_i,
  input  logic               ctrl_board_i,
  input  logic               ctrl_link_i,
  output logic               pll_start_o,
  output logic [MULT_W-1:0]  pll_mult_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic               sys_rst_no,
  output logic               cpu0_rst_no,
  output logic               board_rst_no,
  output logic               pci_rst_no,
  output logic               link_rst_no,
  output logic               link_pwrok_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               rst_sync_n, warm_sync_n;
  logic [CAUSE_W-1:0] grant;
  seq_state_e         state;
  logic               board_seq, link_cold, mult_cap, cfg_cap;

  rst_sync #(.STAGES(SYNC_N)) i_cold_sync (
    .clk_i(clk_i), .arst_ni(rst_ni), .sync_no(rst_sync_n));
  rst_sync #(.STAGES(SYNC_N)) i_warm_sync (
    .clk_i(clk_i), .arst_ni(warm_rst_ni), .sync_no(warm_sync_n));

  rst_req_arb i_arb (
    .sw_soft_i(sw_soft_req_i), .sw_sys_i(sw_sys_req_i),
    .wdt_soft_i(wdt_soft_req_i), .wdt_sys_i(wdt_sys_req_i),
    .grant_o(grant));

  rst_seq_fsm #(.LOCK_CYC(LOCK_CYC), .INT_CYC(INT_CYC)) i_fsm (
    .clk_i(clk_i), .rst_sync_ni(rst_sync_n), .warm_sync_ni(warm_sync_n),
    .grant_i(grant), .state_o(state), .board_seq_o(board_seq),
    .link_cold_o(link_cold), .cause_o(cause_o),
    .mult_cap_o(mult_cap), .cfg_cap_o(cfg_cap));

  rst_cfg_capture #(.MULT_W(MULT_W), .CFG_W(CFG_W)) i_cap (
    .clk_i(clk_i), .rst_sync_ni(rst_sync_n), .mult_cap_i(mult_cap),
    .cfg_cap_i(cfg_cap), .pll_mult_i(pll_mult_i), .cfg_bus_i(cfg_bus_i),
    .pll_mult_o(pll_mult_o), .cfg_o(cfg_o));

  rst_out_ctrl i_out (
    .clk_i(clk_i), .rst_sync_ni(rst_sync_n), .state_i(state),
    .board_seq_i(board_seq), .link_cold_i(link_cold),
    .ctrl_we_i(ctrl_we_i), .ctrl_board_i(ctrl_board_i),
    .ctrl_link_i(ctrl_link_i), .pll_start_o(pll_start_o),
    .sys_rst_no(sys_rst_no), .cpu0_rst_no(cpu0_rst_no),
    .board_rst_no(board_rst_no), .pci_rst_no(pci_rst_no),
    .link_rst_no(link_rst_no), .link_pwrok_o(link_pwrok_o));

  a_r2_pll_hold: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    pll_start_o |=> (pll_start_o && $stable(pll_mult_o)));
  a_r7_pci_with_sys: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(pci_rst_no) |-> $rose(sys_rst_no));
  a_r4_cpu_last: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cpu0_rst_no |-> sys_rst_no);
endmodule

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;
  localparam int L  = 8;
  localparam int I  = 4;
  localparam int MW = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0, warm_rst_ni = 1'b1;
  logic sw_soft = 0, sw_sys = 0, wdt_soft = 0, wdt_sys = 0;
  logic [MW-1:0] mult_in = '0;
  logic [CW-1:0] cfg_in = '0;
  logic ctrl_we = 0, ctrl_board = 0, ctrl_link = 0;
  logic pll_start, sys_n, cpu0_n, board_n, pci_n, link_n, pwrok;
  logic [MW-1:0] mult_out;
  logic [CW-1:0] cfg_out;
  logic [5:0] cause;

  rst_seq_ctrl #(.LOCK_CYC(L), .INT_CYC(I), .MULT_W(MW), .CFG_W(CW)) i_rst_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .warm_rst_ni(warm_rst_ni),
    .sw_soft_req_i(sw_soft), .sw_sys_req_i(sw_sys),
    .wdt_soft_req_i(wdt_soft), .wdt_sys_req_i(wdt_sys),
    .pll_mult_i(mult_in), .cfg_bus_i(cfg_in), .ctrl_we_i(ctrl_we),
    .ctrl_board_i(ctrl_board), .ctrl_link_i(ctrl_link),
    .pll_start_o(pll_start), .pll_mult_o(mult_out), .cfg_o(cfg_out),
    .sys_rst_no(sys_n), .cpu0_rst_no(cpu0_n), .board_rst_no(board_n),
    .pci_rst_no(pci_n), .link_rst_no(link_n), .link_pwrok_o(pwrok),
    .cause_o(cause));

  int nchk = 0, nfail = 0;
  logic [CW-1:0] exp_cfg;
  logic [MW-1:0] exp_mult;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk_running(input string req);
    chk(req, {sys_n, cpu0_n, board_n, pci_n, link_n, pwrok}, 6'b111111);
  endtask

  task automatic cold_boot(input bit warm_pulse);
    rst_ni = 1'b0;
    cfg_in = '0;
    mult_in = '0;
    repeat (3) cyc();
    chk("R1 outputs in cold", {pll_start, sys_n, cpu0_n, board_n, pci_n, link_n, pwrok}, 7'b0);
    chk("R1 R12 cause in cold", cause, 6'b000001);
    rst_ni = 1'b1;
    for (int k = 1; k <= L + I + 6; k++) begin
      cyc();
      chk("R2 pll start", pll_start, k >= 3);
      chk("R4 sys release", sys_n, k >= 3 + L + I);
      chk("R4 cpu0 release", cpu0_n, k >= 4 + L + I);
      chk("R7 pci", pci_n, k >= 3 + L + I);
      chk("R7 link power-good", pwrok, k >= 3 + L + I);
      chk("R9 board", board_n, k >= 3 + L + I);
      if (k >= 3) chk("R2 mult capture", mult_out, 2);
      if (k >= 3 + L) chk("R3 cfg capture", cfg_out, CW'(2 + L));
      if (warm_pulse && k == 4) warm_rst_ni = 1'b0;  // R6
      if (warm_pulse && k == 6) warm_rst_ni = 1'b1;
      cfg_in = CW'(k);
      mult_in = MW'(k);
    end
    chk("R12 cause after cold", cause, 6'b000001);
    exp_cfg = CW'(2 + L);
    exp_mult = 2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2;
    cold_boot(1'b0);

    // R5/R11: warm with simultaneous watchdog system request; warm wins
    cyc();
    warm_rst_ni = 1'b0;
    wdt_sys = 1'b1;
    cyc();
    wdt_sys = 1'b0;
    chk("R5 warm enters reset", {sys_n, cpu0_n, board_n, pci_n, link_n}, 5'b0);
    chk("R7 pwrok high on warm", pwrok, 1);
    chk("R5 pll stays", pll_start, 1);
    chk("R11 R12 warm wins", cause, 6'b000010);
    cfg_in = 8'hA5;
    mult_in = 4'hF;
    repeat (3) cyc();
    warm_rst_ni = 1'b1;
    for (int k = 1; k <= I + 5; k++) begin
      cyc();
      chk("R5 sys after warm", sys_n, k >= 3 + I);
      chk("R5 cpu0 after warm", cpu0_n, k >= 4 + I);
      chk("R5 pll stays", pll_start, 1);
      chk("R5 cfg kept", cfg_out, exp_cfg);
      chk("R5 mult kept", mult_out, exp_mult);
    end

    // R11: no request, nothing happens
    cyc();
    chk_running("R11 idle");

    // R9 R10 R11 R12: all request combinations
    for (int c = 1; c < 16; c++) begin
      logic [5:0] ec;
      logic sysk;
      if (c[3])      ec = 6'b100000;
      else if (c[1]) ec = 6'b001000;
      else if (c[2]) ec = 6'b010000;
      else           ec = 6'b000100;
      sysk = c[3] | c[1];
      sw_soft = c[0]; sw_sys = c[1]; wdt_soft = c[2]; wdt_sys = c[3];
      cfg_in = CW'(8'h40 + c);
      cyc();
      sw_soft = 0; sw_sys = 0; wdt_soft = 0; wdt_sys = 0;
      if (ec == 6'b001000) exp_cfg = CW'(8'h40 + c);
      chk("R11 R12 cause", cause, ec);
      chk("R9 board", board_n, !sysk);
      chk("R7 in reset", {sys_n, cpu0_n, pci_n, link_n, pwrok}, 5'b00001);
      chk("R10 cfg", cfg_out, exp_cfg);
      for (int j = 2; j <= I + 2; j++) begin
        if (j == 3) sw_sys = 1'b0;
        cyc();
        chk("R4 sys", sys_n, j >= 1 + I);
        chk("R4 cpu0", cpu0_n, j >= 2 + I);
        if (j == 2) begin sw_sys = 1'b1; cfg_in = 8'hEE; end  // R11 ignored
      end
      chk("R11 cause kept", cause, ec);
      chk("R10 cfg after", cfg_out, exp_cfg);
      chk("R10 mult after", mult_out, exp_mult);
      chk_running("R4 running");
    end

    // R8: software output control
    for (int v = 0; v < 4; v++) begin
      ctrl_we = 1; ctrl_board = v[0]; ctrl_link = v[1];
      cyc();
      ctrl_we = 0;
      chk("R8 board ctrl", board_n, !v[0]);
      chk("R8 link ctrl", link_n, !v[1]);
      chk("R8 pci no ctrl", pci_n, 1);
      chk("R8 cpu0 running", cpu0_n, 1);
    end
    sw_soft = 1;
    cyc();
    sw_soft = 0;
    cyc();
    ctrl_we = 1; ctrl_board = 1; ctrl_link = 1;  // dropped during reset
    cyc();
    ctrl_we = 0;
    repeat (I) cyc();
    chk_running("R8 bits cleared and write dropped");

    cold_boot(1'b1);
    chk_running("R6 running after cold");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule